// File: doc/BRIEF.md
# Boot Record Initialization Sequencer

This block is the reset-time controller that takes a processor core from reset to its first instruction fetch. Once reset is released it optionally waits on a built-in self-test, loads a fixed process-control word, and reads a boot record through a narrow read port that allows one read in flight. The record lives at a fixed base address. Its first four words each carry one byte of the initial bus-region configuration and the memory endianness. Its next eight words are protected by an end-around-carry checksum.

When the checksum sums to zero, the block pulses a done strobe. With that strobe it presents the first instruction address, the control-block pointer, the assembled configuration, the endianness bit, the process-control word and a device identification value for general register 0. All of these then hold until the next reset. When the checksum is bad, the block issues one diagnostic read to a fixed address and stops for good. The FAIL pin stays asserted in that case.

The FAIL output follows a fixed sequence. It is high in reset, low for one cycle once reset and any self-test are done, high again while the record is read, and low again only on success.

Top module: `boot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `fail_o`=1, `mem_req_o`=0, `done_o`=0, `region_cfg_o`=0 (8-bit bus width), `big_endian_o`=0, `dcache_en_o`=0, `int_mask_o`=0 and `lmem_prot_en_o`=0. This holds from any state, including mid-read and the terminal failure state.
- R2: If `selftest_req` is high in the last reset cycle, no read is issued and `fail_o` stays 1 until `selftest_done` is seen. If `selftest_pass` is 0 with it, the block never reads and `fail_o` stays 1.
- R3: Between leaving reset (or a passing self-test) and the first read, `fail_o` is low for exactly one cycle. `fail_o` is 1 whenever `mem_req_o` is 1.
- R4: At `done_o`, `proc_ctrl_o` is 0x001F2002, and `dcache_en_o`, `int_mask_o` and `lmem_prot_en_o` are all 0.
- R5: The record is read as 12 words at addresses 0xFEFFFF30 + 4·k, k = 0..11, in ascending order. `mem_req_o` and `mem_addr_o` hold until `mem_ready_i` is seen at a clock edge.
- R6: `region_cfg_o` is 0x00XX0000. XX is bits 7:0 of the word at base+0x8 ANDed with 0xC0. Bits 31:8 of that word and the words at base+0x0 and base+0x4 have no effect.
- R7: `big_endian_o` equals bit 7 of the word read at base+0xC.
- R8: The checksum starts at 0xFFFFFFFF with carry 0. Each of the words at base+0x10 .. base+0x2C is added with the previous carry-out, and the record is valid only if the final 32-bit sum is zero.
- R9: On a valid record, `done_o` pulses for one cycle with `fail_o`=0. `first_ip_o` equals the word at base+0x10, `cb_ptr_o` the word at base+0x14, and `gr0_o` equals DEVICE_ID. No further reads follow, and these outputs and `fail_o`=0 hold until reset.
- R10: On an invalid record, exactly one read to 0xFEFFFF64 follows the 12 record reads. After it there is no request and no `done_o`, and `fail_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| selftest_req | input | 1 | Self-test requested; sampled while reset is high |
| selftest_done | input | 1 | Self-test finished |
| selftest_pass | input | 1 | Self-test result, valid with `selftest_done` |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read address |
| mem_ready_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| fail_o | output | 1 | FAIL indication |
| done_o | output | 1 | One-cycle completion strobe |
| first_ip_o | output | 32 | First instruction address |
| cb_ptr_o | output | 32 | Control-block pointer |
| region_cfg_o | output | 32 | Default region configuration |
| big_endian_o | output | 1 | Initial memory endianness |
| proc_ctrl_o | output | 32 | Initial process-control word |
| gr0_o | output | 32 | Value for general register 0 |
| dcache_en_o | output | 1 | Data cache enable |
| int_mask_o | output | 32 | Interrupt mask |
| lmem_prot_en_o | output | 2 | Local-memory protection enables |

## Verification
The hardest case to reach is a record whose carry chain matters, because a checksum that ignores carries still passes many records. The bench builds each record with seven chosen words and computes the eighth so that the end-around sum is exactly zero. Some records use near-all-ones words, which makes every add carry. A single-bit flip then gives the failing case. The terminal state is reached through that failed record and left again only through reset. A second reset is dropped in while a read is stalled on a slow `mem_ready_i`.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [3:0] {
        ST_ENTRY,
        ST_SELFTEST,
        ST_STUCK,
        ST_SETUP,
        ST_PREP,
        ST_READ,
        ST_CHECK,
        ST_DIAG,
        ST_HANG,
        ST_FINISH,
        ST_IDLE
    } seq_state_e;

    // Bits of the bus-width byte that survive into the region configuration
    localparam logic [7:0] WIDTH_FIELD_MASK = 8'hC0;

endpackage

// File: rtl/boot_csum_step.sv
module boot_csum_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_i,
    input  logic         carry_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] acc_o,
    output logic         carry_o
);
    logic [W:0] total;

    always_comb begin
        total   = {1'b0, word_i} + {1'b0, acc_i} + {{W{1'b0}}, carry_i};
        acc_o   = total[W-1:0];
        carry_o = total[W];
    end
endmodule

// File: rtl/boot_cfg_merge.sv
module boot_cfg_merge
    import boot_seq_pkg::*;
#(
    parameter int NB         = 4,
    parameter int IDX_W      = 4,
    parameter int FIELD_BYTE = 2
) (
    input  logic [IDX_W-1:0] slot_i,
    input  logic             wr_i,
    input  logic [7:0]       byte_i,
    input  logic [8*NB-1:0]  cfg_i,
    input  logic             endian_i,
    output logic [8*NB-1:0]  cfg_o,
    output logic             endian_o
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        localparam logic [7:0] KEEP = (b == FIELD_BYTE) ? WIDTH_FIELD_MASK : 8'h00;
        always_comb begin
            cfg_o[8*b +: 8] = cfg_i[8*b +: 8];
            if (wr_i && slot_i == IDX_W'(b)) begin
                cfg_o[8*b +: 8] = byte_i & KEEP;
            end
        end
    end

    // The top bit of the last byte sets the endianness
    always_comb begin
        endian_o = endian_i;
        if (wr_i && slot_i == IDX_W'(NB - 1)) begin
            endian_o = byte_i[7];
        end
    end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_seq_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter int          CFG_WORDS    = 4,
    parameter int          CSUM_WORDS   = 8,
    parameter int          MASK_W       = 32,
    parameter int          LMEM_REGIONS = 2,
    parameter logic [31:0] BOOT_BASE    = 32'hFEFF_FF30,
    parameter logic [31:0] DIAG_ADDR    = 32'hFEFF_FF64,
    parameter logic [31:0] PC_INIT      = 32'h001F_2002,
    parameter logic [31:0] DEVICE_ID    = 32'h1A2B_3C4D
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    selftest_req,
    input  logic                    selftest_done,
    input  logic                    selftest_pass,
    output logic                    mem_req_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    input  logic                    mem_ready_i,
    input  logic [DATA_W-1:0]       mem_rdata_i,
    output logic                    fail_o,
    output logic                    done_o,
    output logic [DATA_W-1:0]       first_ip_o,
    output logic [DATA_W-1:0]       cb_ptr_o,
    output logic [8*CFG_WORDS-1:0]  region_cfg_o,
    output logic                    big_endian_o,
    output logic [DATA_W-1:0]       proc_ctrl_o,
    output logic [DATA_W-1:0]       gr0_o,
    output logic                    dcache_en_o,
    output logic [MASK_W-1:0]       int_mask_o,
    output logic [LMEM_REGIONS-1:0] lmem_prot_en_o
);
    localparam int N_READS  = CFG_WORDS + CSUM_WORDS;
    localparam int IDX_W    = $clog2(N_READS);
    localparam int CFG_W    = 8 * CFG_WORDS;
    localparam int IP_SLOT  = CFG_WORDS;
    localparam int PTR_SLOT = CFG_WORDS + 1;
    localparam int LAST     = N_READS - 1;

    typedef struct packed {
        seq_state_e              state;
        logic [IDX_W-1:0]        idx;
        logic [DATA_W-1:0]       sum;
        logic                    carry;
        logic                    st_req;
        logic                    fail;
        logic                    done;
        logic [CFG_W-1:0]        cfg;
        logic                    endian;
        logic [DATA_W-1:0]       ip_hold;
        logic [DATA_W-1:0]       ptr_hold;
        logic [DATA_W-1:0]       first_ip;
        logic [DATA_W-1:0]       cb_ptr;
        logic [DATA_W-1:0]       pc;
        logic [DATA_W-1:0]       g0;
        logic                    dcache;
        logic [MASK_W-1:0]       imask;
        logic [LMEM_REGIONS-1:0] lmprot;
    } seq_t;

    seq_t q, d;

    logic              req_d;
    logic [ADDR_W-1:0] addr_d;
    logic              take;
    logic              cfg_wr;
    logic [CFG_W-1:0]  cfg_nx;
    logic              endian_nx;
    logic [DATA_W-1:0] sum_nx;
    logic              carry_nx;

    assign take   = (q.state == ST_READ) && mem_ready_i;
    assign cfg_wr = take && (q.idx < IDX_W'(CFG_WORDS));

    boot_cfg_merge #(
        .NB         (CFG_WORDS),
        .IDX_W      (IDX_W),
        .FIELD_BYTE (2)
    ) u_cfg (
        .slot_i   (q.idx),
        .wr_i     (cfg_wr),
        .byte_i   (mem_rdata_i[7:0]),
        .cfg_i    (q.cfg),
        .endian_i (q.endian),
        .cfg_o    (cfg_nx),
        .endian_o (endian_nx)
    );

    boot_csum_step #(
        .W (DATA_W)
    ) u_csum (
        .acc_i   (q.sum),
        .carry_i (q.carry),
        .word_i  (mem_rdata_i),
        .acc_o   (sum_nx),
        .carry_o (carry_nx)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        req_d  = 1'b0;
        addr_d = BOOT_BASE + ADDR_W'({q.idx, 2'b00});
        case (q.state)
            ST_ENTRY:    d.state = q.st_req ? ST_SELFTEST : ST_SETUP;
            ST_SELFTEST: begin
                if (selftest_done) begin
                    d.state = selftest_pass ? ST_SETUP : ST_STUCK;
                end
            end
            ST_STUCK:    d.state = ST_STUCK;
            ST_SETUP: begin
                d.fail  = 1'b0;
                d.pc    = PC_INIT;
                d.state = ST_PREP;
            end
            ST_PREP: begin
                d.fail   = 1'b1;
                d.dcache = 1'b0;
                d.imask  = '0;
                d.lmprot = '0;
                d.sum    = '1;
                d.carry  = 1'b0;
                d.idx    = '0;
                d.state  = ST_READ;
            end
            ST_READ: begin
                req_d = 1'b1;
                if (mem_ready_i) begin
                    d.cfg    = cfg_nx;
                    d.endian = endian_nx;
                    if (q.idx >= IDX_W'(CFG_WORDS)) begin
                        d.sum   = sum_nx;
                        d.carry = carry_nx;
                    end
                    if (q.idx == IDX_W'(IP_SLOT))  d.ip_hold  = mem_rdata_i;
                    if (q.idx == IDX_W'(PTR_SLOT)) d.ptr_hold = mem_rdata_i;
                    if (q.idx == IDX_W'(LAST)) begin
                        d.state = ST_CHECK;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_CHECK:    d.state = (q.sum == '0) ? ST_FINISH : ST_DIAG;
            ST_DIAG: begin
                req_d  = 1'b1;
                addr_d = DIAG_ADDR;
                if (mem_ready_i) d.state = ST_HANG;
            end
            ST_HANG:     d.state = ST_HANG;
            ST_FINISH: begin
                d.fail     = 1'b0;
                d.done     = 1'b1;
                d.first_ip = q.ip_hold;
                d.cb_ptr   = q.ptr_hold;
                d.g0       = DEVICE_ID;
                d.state    = ST_IDLE;
            end
            ST_IDLE:     d.state = ST_IDLE;
            default:     d.state = ST_ENTRY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.state  <= ST_ENTRY;
            q.fail   <= 1'b1;
            q.st_req <= selftest_req;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o      = req_d;
    assign mem_addr_o     = addr_d;
    assign fail_o         = q.fail;
    assign done_o         = q.done;
    assign first_ip_o     = q.first_ip;
    assign cb_ptr_o       = q.cb_ptr;
    assign region_cfg_o   = q.cfg;
    assign big_endian_o   = q.endian;
    assign proc_ctrl_o    = q.pc;
    assign gr0_o          = q.g0;
    assign dcache_en_o    = q.dcache;
    assign int_mask_o     = q.imask;
    assign lmem_prot_en_o = q.lmprot;

    // R1: reset forces the idle, failing, unconfigured state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> fail_o && !mem_req_o && !done_o && region_cfg_o == '0);

    // R3: FAIL is raised while the boot record is being fetched
    p_fail_on_read_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> fail_o);

    // R5: a pending request keeps its address until accepted
    p_req_held_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

    // R9: completion is a single-cycle strobe with FAIL released
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !fail_o && !mem_req_o);

    // R9: results hold after completion
    p_hold_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        q.state == ST_IDLE |=> $stable(first_ip_o) && $stable(cb_ptr_o) && $stable(region_cfg_o));

    // R10: the diagnostic read is the last request
    p_diag_last_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ready_i && mem_addr_o == DIAG_ADDR |=> !mem_req_o && fail_o);
endmodule

// File: tb/boot_seq_tb.sv
`timescale 1ns/1ps
module boot_seq_tb;
    localparam logic [31:0] BASE  = 32'hFEFF_FF30;
    localparam logic [31:0] DIAG  = 32'hFEFF_FF64;
    localparam logic [31:0] PCV   = 32'h001F_2002;
    localparam logic [31:0] DEVID = 32'h1A2B_3C4D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        selftest_req = 1'b0, selftest_done = 1'b0, selftest_pass = 1'b0;
    logic        mem_req_o, mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_rdata_i = '0;
    logic        fail_o, done_o, big_endian_o, dcache_en_o;
    logic [31:0] first_ip_o, cb_ptr_o, region_cfg_o, proc_ctrl_o, gr0_o, int_mask_o;
    logic [1:0]  lmem_prot_en_o;

    boot_seq #(.DEVICE_ID(DEVID)) u_dut (
        .clk(clk), .rst(rst), .selftest_req(selftest_req), .selftest_done(selftest_done),
        .selftest_pass(selftest_pass), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i), .fail_o(fail_o), .done_o(done_o),
        .first_ip_o(first_ip_o), .cb_ptr_o(cb_ptr_o), .region_cfg_o(region_cfg_o),
        .big_endian_o(big_endian_o), .proc_ctrl_o(proc_ctrl_o), .gr0_o(gr0_o),
        .dcache_en_o(dcache_en_o), .int_mask_o(int_mask_o), .lmem_prot_en_o(lmem_prot_en_o)
    );

    always #4 clk = ~clk;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] rec [12];
    logic [31:0] expq [$];
    int          lat = 0;
    int          wcnt = 0;
    bit          quiet = 0;   // model: no request is legal now

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= BASE && a < BASE + 32'd48) return rec[(a - BASE) >> 2];
        return 32'hD1A6_0000 ^ a;
    endfunction

    // Memory responder and per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && mem_req_o) begin
            chk(fail_o, "R3", "fail_o during read", {31'b0, fail_o}, 32'h1);
            chk(!quiet, "R2/R10", "request while quiet", mem_addr_o, 32'h0);
        end
        if (!rst && mem_req_o && wcnt >= lat) begin
            mem_ready_i <= 1'b1;
            mem_rdata_i <= mem_word(mem_addr_o);
            wcnt = 0;
            if (expq.size() == 0) begin
                chk(1'b0, "R5", "unexpected read", mem_addr_o, 32'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(mem_addr_o == e, "R5", "read address", mem_addr_o, e);
            end
        end else begin
            mem_ready_i <= 1'b0;
            if (!rst && mem_req_o) wcnt++;
        end
    end

    // Build a record; the last checksum word makes the end-around sum zero
    task automatic make_rec(input bit good, input bit heavy, input logic [7:0] b8, input logic [7:0] bc);
        logic [32:0] t;
        logic [31:0] s;
        logic        c;
        rec[0] = $urandom();
        rec[1] = $urandom();
        rec[2] = {$urandom() % 32'h0100_0000, 8'h00} | {24'h0, b8};
        rec[3] = {$urandom() % 32'h0100_0000, 8'h00} | {24'h0, bc};
        for (int k = 4; k < 11; k++) rec[k] = heavy ? (32'hFFFF_FFF0 | ($urandom() % 16)) : $urandom();
        s = 32'hFFFF_FFFF;
        c = 1'b0;
        for (int k = 4; k < 11; k++) begin
            t = {1'b0, rec[k]} + {1'b0, s} + {32'b0, c};
            s = t[31:0];
            c = t[32];
        end
        rec[11] = 32'h0 - (s + {31'b0, c});
        if (!good) rec[11] = rec[11] ^ 32'h0000_0100;
    endtask

    task automatic do_reset(input bit st);
        rst = 1'b1;
        selftest_req = st;
        quiet = 0;
        repeat (3) @(negedge clk);
        chk(fail_o && !mem_req_o && !done_o, "R1", "fail/req/done in reset",
            {29'b0, fail_o, mem_req_o, done_o}, 32'h4);
        chk(region_cfg_o == 0 && !big_endian_o, "R1", "region cfg in reset", region_cfg_o, 32'h0);
        chk(!dcache_en_o && int_mask_o == 0 && lmem_prot_en_o == 0, "R1", "cache/mask/prot in reset",
            int_mask_o, 32'h0);
        rst = 1'b0;
        selftest_req = 1'b0;
    endtask

    task automatic boot_run(input bit st, input int l, input bit good, input bit heavy,
                            input logic [7:0] b8, input logic [7:0] bc);
        int lows;
        int guard;
        make_rec(good, heavy, b8, bc);
        expq.delete();
        for (int k = 0; k < 12; k++) expq.push_back(BASE + 32'(4 * k));
        if (!good) expq.push_back(DIAG);
        lat = l;
        wcnt = 0;
        do_reset(st);
        if (st) begin
            quiet = 1;
            repeat (20) @(negedge clk);
            chk(fail_o, "R2", "fail_o while self-test runs", {31'b0, fail_o}, 32'h1);
            quiet = 0;
            selftest_done = 1'b1;
            selftest_pass = 1'b1;
            @(negedge clk);
            selftest_done = 1'b0;
            selftest_pass = 1'b0;
        end
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            if (mem_req_o) break;
            if (!fail_o) lows++;
            @(negedge clk);
        end
        chk(lows == 1, "R3", "fail_o low cycles before first read", lows, 1);
        if (good) begin
            guard = 0;
            while (!done_o && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            chk(done_o && !fail_o, "R9", "done with fail low", {30'b0, done_o, fail_o}, 32'h2);
            chk(first_ip_o == rec[4], "R9", "first ip", first_ip_o, rec[4]);
            chk(cb_ptr_o == rec[5], "R9", "control-block pointer", cb_ptr_o, rec[5]);
            chk(gr0_o == DEVID, "R9", "g0", gr0_o, DEVID);
            chk(region_cfg_o == {8'h00, b8 & 8'hC0, 16'h0}, "R6", "region cfg", region_cfg_o,
                {8'h00, b8 & 8'hC0, 16'h0});
            chk(big_endian_o == bc[7], "R7", "endianness", {31'b0, big_endian_o}, {31'b0, bc[7]});
            chk(proc_ctrl_o == PCV, "R4", "process-control word", proc_ctrl_o, PCV);
            chk(!dcache_en_o && int_mask_o == 0 && lmem_prot_en_o == 0, "R4", "cache/mask/prot",
                {int_mask_o[29:0], lmem_prot_en_o} | {31'b0, dcache_en_o}, 32'h0);
            chk(expq.size() == 0, "R8", "valid record accepted after 12 reads", expq.size(), 0);
            quiet = 1;
            repeat (15) @(negedge clk);
            chk(!done_o && !fail_o, "R9", "single strobe, fail stays low", {30'b0, done_o, fail_o}, 32'h0);
            chk(first_ip_o == rec[4] && cb_ptr_o == rec[5], "R9", "results held", first_ip_o, rec[4]);
        end else begin
            guard = 0;
            while (expq.size() != 0 && guard < 2000) begin
                @(negedge clk);
                guard++;
            end
            chk(expq.size() == 0, "R10", "diagnostic read issued", expq.size(), 0);
            @(negedge clk);
            quiet = 1;
            repeat (40) begin
                @(negedge clk);
                if (done_o || !fail_o) chk(1'b0, "R8", "bad record finished", {31'b0, done_o}, 32'h0);
            end
            chk(fail_o && !done_o, "R10", "hang with fail high", {30'b0, fail_o, done_o}, 32'h2);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        boot_run(0, 0, 1, 0, 8'hFF, 8'h80);
        boot_run(0, 2, 1, 1, 8'h7F, 8'h7F);
        boot_run(1, 1, 1, 0, 8'h3F, 8'hC3);
        boot_run(0, 3, 0, 0, 8'hC0, 8'h00);
        boot_run(0, 1, 1, 1, 8'h80, 8'hFF);   // R1: recovery from hang
        boot_run(0, 0, 0, 1, 8'h40, 8'h80);   // R8: carry-heavy bad record
        // R2: failing self-test never reads
        do_reset(1);
        repeat (5) @(negedge clk);
        selftest_done = 1'b1;
        selftest_pass = 1'b0;
        quiet = 1;
        @(negedge clk);
        selftest_done = 1'b0;
        repeat (40) @(negedge clk);
        chk(fail_o && !mem_req_o, "R2", "failed self-test stuck", {30'b0, fail_o, mem_req_o}, 32'h2);
        // R1: reset while a read is stalled
        quiet = 0;
        make_rec(1, 0, 8'hC0, 8'h80);
        expq.delete();
        for (int k = 0; k < 12; k++) expq.push_back(BASE + 32'(4 * k));
        lat = 1000;
        wcnt = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(mem_req_o && mem_addr_o == BASE, "R5", "stalled request held", mem_addr_o, BASE);
        rst = 1'b1;
        @(negedge clk);
        chk(fail_o && !mem_req_o && region_cfg_o == 0, "R1", "reset mid-read", {31'b0, mem_req_o}, 32'h0);
        boot_run(0, 1, 1, 0, 8'hFF, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule